// File: doc/BRIEF.md
# Daisy-Chain Crosspoint Configuration Sequencer

This block sits on the host side of a serial chain of crosspoint configuration devices. Software or a neighbouring controller writes one 40-bit configuration word per device into an internal word store. It then pulses `start`. The sequencer asserts chip enable and clocks out all 40×N bits on a divided serial clock. It then commits every device at once with a single low pulse on the update line. The chain is wired so that data shifted in at the first device ripples towards the last. For that reason the word for the farthest device leaves first.

Each 40-bit word holds eight 5-bit output groups. Output k occupies word bits [5k+4:5k] as {enable, reserved, select[2], select[1], select[0]}. Word bits are sent from bit 39 down to bit 0. The result is that outputs go from the highest down to output 0, and within a group the order is enable, reserved, then select MSB first. The reserved position is always sent as 1, whatever was loaded. The update line stays high for the whole shift. Update and chip enable are never low together until a complete chain image has been shifted, so random power-up contents can never be committed.

Top module: `xp_chain_programmer`

## Requirements
- R1: After reset, `xp_ce_n`=1, `xp_upd_n`=1, `xp_sclk`=1 and `done`=0, and they hold these levels until a start is accepted.
- R2: One sequence produces exactly 40×N_DEV falling edges of `xp_sclk` while `xp_ce_n` is low.
- R3: Device order is highest index first. The word loaded for device N_DEV-1 fills the first 40 bits, and the word for device 0 fills the last 40.
- R4: Within a word, bits leave from bit 39 down to bit 0. For output k the order is enable (bit 5k+4), reserved (bit 5k+3), then select bits 5k+2, 5k+1, 5k.
- R5: Every reserved position (word bit 5k+3) is transmitted as 1 regardless of the loaded value.
- R6: `xp_sdi` changes only together with a rising `xp_sclk` and is stable across each falling edge. Each high and each low phase lasts `half_len` system cycles, and a value of 0 acts as 1.
- R7: `xp_upd_n` stays high during the shift. After the last bit's low phase it goes low for `pulse_len` cycles, and 0 acts as 1. `xp_ce_n` stays low throughout the shift and the commit.
- R8: `xp_upd_n` and `xp_ce_n` are never low together unless all 40×N_DEV bits of the current sequence have been shifted.
- R9: In the cycle after the commit pulse ends, `xp_upd_n` and `xp_ce_n` are both high and `done` is high for exactly one cycle.
- R10: A `start` while a sequence runs is ignored. A `cfg_wr` while a sequence runs is ignored: neither the current nor a later stream uses that data.
- R11: `xp_serpar` is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write `cfg_word` into the store slot `cfg_dev` (idle only) |
| cfg_dev | input | DEV_W | Chain position of the device being written (0 = nearest the host) |
| cfg_word | input | 40 | Configuration word, eight 5-bit output groups |
| half_len | input | CNT_W | Serial clock half period in system cycles |
| pulse_len | input | CNT_W | Commit pulse length in system cycles |
| start | input | 1 | Begin a full chain programming sequence |
| xp_ce_n | output | 1 | Chain chip enable, active low |
| xp_sclk | output | 1 | Serial clock, idle high, data captured on falling edge |
| xp_sdi | output | 1 | Serial data into the first device |
| xp_upd_n | output | 1 | Update line, low commits shifted data |
| xp_serpar | output | 1 | Serial/parallel select, held low (serial) |
| done | output | 1 | One-cycle pulse when the commit completes |

## Verification
A bound checker watches the timing rules every cycle. It counts falling serial clock edges and requires the full 40×N_DEV count whenever update is low (with chip enable low). It measures each serial clock phase and each commit pulse against the lengths latched at start. It also enforces data stability across falling edges and the one-cycle `done` shape. Bit order, device order, the forced reserved bits and the rejection of loads and starts during a run are content and history properties. Only the bench scenarios show those, by rebuilding the expected 120-bit stream from the loaded words and comparing it bit by bit.

// File: rtl/xp_seq_pkg.sv
// Package: shared constants and state type for the chain programming sequencer.
// Assumes every chained device takes a 40-bit word of eight 5-bit output groups.
package xp_seq_pkg;
    localparam int WORD_W  = 40;
    localparam int GROUP_W = 5;
    localparam int POS_W   = 6;
    localparam int SLOT_W  = 3;
    // slot index of the reserved bit inside a group, in transmit order
    localparam int RSV_SLOT = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/xp_cfg_store.sv
// Module: word store holding one configuration word per chained device.
// Provides a combinational bit read at (device, bit position) and forces the
// reserved slot of each group to 1. Writes are gated by the caller.
module xp_cfg_store
    import xp_seq_pkg::*;
#(
    parameter int N_DEV = 3,
    parameter int DEV_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DEV_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DEV_W-1:0]  rd_dev,
    input  logic [POS_W-1:0]  rd_pos,
    input  logic              rd_rsv,
    output logic              rd_bit
);
    logic [WORD_W-1:0] mem [N_DEV];

    generate
        for (genvar d = 0; d < N_DEV; d++) begin : g_slot
            // purpose: capture the word addressed to this chain position
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[d] <= '0;
                end else if (wr_en && (wr_idx == DEV_W'(d))) begin
                    mem[d] <= wr_word;
                end
            end
        end
    endgenerate

    // purpose: select the addressed bit, reserved slots always read as 1
    always_comb begin
        rd_bit = 1'b0;
        if (rd_rsv) begin
            rd_bit = 1'b1;
        end else if (int'(rd_dev) < N_DEV) begin
            rd_bit = mem[rd_dev][rd_pos];
        end
    end
endmodule

// File: rtl/xp_half_timer.sv
// Module: phase timer shared by the serial clock and the commit pulse.
// Emits a one-cycle tick every len cycles while run is high; len must be >= 1.
module xp_half_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == (len - CNT_W'(1)));

    // purpose: count cycles inside the current phase, restart on tick or idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/xp_seq_ctrl.sv
// Module: sequencing FSM. Walks the chain from the farthest device down to
// device 0, each word from bit 39 to bit 0, sets data with the rising serial
// clock, then drives the commit pulse and the done strobe.
// Assumes the store read is combinational and the timer tick has no latency.
module xp_seq_ctrl
    import xp_seq_pkg::*;
#(
    parameter int N_DEV = 3,
    parameter int DEV_W = 2,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  half_len,
    input  logic [CNT_W-1:0]  pulse_len,
    input  logic              tick,
    input  logic              store_bit,
    output logic              busy,
    output logic [CNT_W-1:0]  phase_len,
    output logic [DEV_W-1:0]  nxt_dev,
    output logic [POS_W-1:0]  nxt_pos,
    output logic              nxt_rsv,
    output logic              ce_n,
    output logic              sclk,
    output logic              sdi,
    output logic              upd_n,
    output logic              done
);
    seq_state_t        state;
    logic [DEV_W-1:0]  dev_q;
    logic [POS_W-1:0]  pos_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] nxt_slot;
    logic              low_phase;
    logic [CNT_W-1:0]  h_q;
    logic [CNT_W-1:0]  l_q;
    logic              last_bit;

    assign busy      = (state != ST_IDLE);
    assign phase_len = (state == ST_COMMIT) ? l_q : h_q;
    assign last_bit  = (dev_q == '0) && (pos_q == '0);
    assign nxt_rsv   = (nxt_slot == SLOT_W'(RSV_SLOT));

    // purpose: address of the bit to present at the next rising serial edge
    always_comb begin
        if (state == ST_IDLE) begin
            nxt_dev  = DEV_W'(N_DEV - 1);
            nxt_pos  = POS_W'(WORD_W - 1);
            nxt_slot = '0;
        end else if (pos_q == '0) begin
            nxt_dev  = dev_q - DEV_W'(1);
            nxt_pos  = POS_W'(WORD_W - 1);
            nxt_slot = '0;
        end else begin
            nxt_dev  = dev_q;
            nxt_pos  = pos_q - POS_W'(1);
            nxt_slot = (slot_q == SLOT_W'(GROUP_W - 1)) ? '0 : slot_q + SLOT_W'(1);
        end
    end

    // purpose: state, pin levels and bit address updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ce_n      <= 1'b1;
            sclk      <= 1'b1;
            sdi       <= 1'b0;
            upd_n     <= 1'b1;
            done      <= 1'b0;
            dev_q     <= '0;
            pos_q     <= '0;
            slot_q    <= '0;
            low_phase <= 1'b0;
            h_q       <= CNT_W'(1);
            l_q       <= CNT_W'(1);
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        h_q       <= (half_len == '0) ? CNT_W'(1) : half_len;
                        l_q       <= (pulse_len == '0) ? CNT_W'(1) : pulse_len;
                        state     <= ST_SHIFT;
                        ce_n      <= 1'b0;
                        sclk      <= 1'b1;
                        sdi       <= store_bit;
                        dev_q     <= nxt_dev;
                        pos_q     <= nxt_pos;
                        slot_q    <= nxt_slot;
                        low_phase <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!low_phase) begin
                            sclk      <= 1'b0;
                            low_phase <= 1'b1;
                        end else begin
                            sclk      <= 1'b1;
                            low_phase <= 1'b0;
                            if (last_bit) begin
                                state <= ST_COMMIT;
                                upd_n <= 1'b0;
                            end else begin
                                sdi    <= store_bit;
                                dev_q  <= nxt_dev;
                                pos_q  <= nxt_pos;
                                slot_q <= nxt_slot;
                            end
                        end
                    end
                end
                ST_COMMIT: begin
                    if (tick) begin
                        upd_n <= 1'b1;
                        ce_n  <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xp_chain_programmer.sv
// Module: top of the daisy-chain serial programming sequencer.
// Loads one word per device while idle, then on start shifts the whole chain
// image and commits it with one update pulse. Assumes a single clock domain
// and that the chain samples data on the falling serial clock edge.
module xp_chain_programmer
    import xp_seq_pkg::*;
#(
    parameter  int N_DEV = 3,
    parameter  int CNT_W = 8,
    localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DEV_W-1:0]  cfg_dev,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [CNT_W-1:0]  half_len,
    input  logic [CNT_W-1:0]  pulse_len,
    input  logic              start,
    output logic              xp_ce_n,
    output logic              xp_sclk,
    output logic              xp_sdi,
    output logic              xp_upd_n,
    output logic              xp_serpar,
    output logic              done
);
    logic             busy;
    logic             tick;
    logic [CNT_W-1:0] phase_len;
    logic [DEV_W-1:0] rd_dev;
    logic [POS_W-1:0] rd_pos;
    logic             rd_rsv;
    logic             rd_bit;

    assign xp_serpar = 1'b0;

    xp_cfg_store #(.N_DEV(N_DEV), .DEV_W(DEV_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr && !busy),
        .wr_idx  (cfg_dev),
        .wr_word (cfg_word),
        .rd_dev  (rd_dev),
        .rd_pos  (rd_pos),
        .rd_rsv  (rd_rsv),
        .rd_bit  (rd_bit)
    );

    xp_half_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .len   (phase_len),
        .tick  (tick)
    );

    xp_seq_ctrl #(.N_DEV(N_DEV), .DEV_W(DEV_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .half_len  (half_len),
        .pulse_len (pulse_len),
        .tick      (tick),
        .store_bit (rd_bit),
        .busy      (busy),
        .phase_len (phase_len),
        .nxt_dev   (rd_dev),
        .nxt_pos   (rd_pos),
        .nxt_rsv   (rd_rsv),
        .ce_n      (xp_ce_n),
        .sclk      (xp_sclk),
        .sdi       (xp_sdi),
        .upd_n     (xp_upd_n),
        .done      (done)
    );
endmodule

// File: rtl/xp_chain_checker.sv
// Module: protocol checker bound to the sequencer top. Counts falling serial
// edges, phase and pulse lengths from the pins and checks them against the
// lengths latched when a start is accepted (chip enable high means idle).
module xp_chain_checker #(
    parameter int N_DEV = 3,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] half_len,
    input logic [CNT_W-1:0] pulse_len,
    input logic             xp_ce_n,
    input logic             xp_sclk,
    input logic             xp_sdi,
    input logic             xp_upd_n,
    input logic             done
);
    localparam int TOTAL = 40 * N_DEV;
    localparam int FC_W  = $clog2(TOTAL + 2);

    logic [FC_W-1:0]  falls;
    logic             prev_sclk;
    logic [CNT_W-1:0] run_len;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] hq;
    logic [CNT_W-1:0] lq;

    // purpose: observation counters and latched phase lengths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            falls     <= '0;
            prev_sclk <= 1'b1;
            run_len   <= '0;
            low_len   <= '0;
            hq        <= CNT_W'(1);
            lq        <= CNT_W'(1);
        end else begin
            prev_sclk <= xp_sclk;
            if (xp_ce_n) falls <= '0;
            else if (prev_sclk && !xp_sclk) falls <= falls + FC_W'(1);
            if (xp_ce_n) run_len <= '0;
            else if (xp_sclk != prev_sclk) run_len <= CNT_W'(1);
            else run_len <= run_len + CNT_W'(1);
            if (xp_upd_n) low_len <= '0;
            else low_len <= low_len + CNT_W'(1);
            if (start && xp_ce_n) begin
                hq <= (half_len == '0) ? CNT_W'(1) : half_len;
                lq <= (pulse_len == '0) ? CNT_W'(1) : pulse_len;
            end
        end
    end

    a_r8_commit_after_full_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !xp_upd_n |-> (!xp_ce_n && (falls == FC_W'(TOTAL))));

    a_r6_phase_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!xp_ce_n && xp_upd_n && (xp_sclk != prev_sclk)) |-> (run_len == hq));

    a_r6_data_stable_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!xp_ce_n && $fell(xp_sclk)) |-> $stable(xp_sdi));

    a_r7_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xp_upd_n) |-> (low_len == lq));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (xp_ce_n && xp_upd_n && $past(!xp_upd_n)));

    a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        xp_ce_n |-> xp_sclk);
endmodule

bind xp_chain_programmer xp_chain_checker #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .half_len  (half_len),
    .pulse_len (pulse_len),
    .xp_ce_n   (xp_ce_n),
    .xp_sclk   (xp_sclk),
    .xp_sdi    (xp_sdi),
    .xp_upd_n  (xp_upd_n),
    .done      (done)
);

// File: tb/sim_xp_chain_programmer.sv
`timescale 1ns/1ps
module sim_xp_chain_programmer;
    localparam int N  = 3;
    localparam int CW = 8;
    localparam int B  = 40 * N;
    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [DW-1:0] cfg_dev = '0;
    logic [39:0]   cfg_word = '0;
    logic [CW-1:0] half_len = 8'd1;
    logic [CW-1:0] pulse_len = 8'd1;
    logic          start = 1'b0;
    logic xp_ce_n, xp_sclk, xp_sdi, xp_upd_n, xp_serpar, done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [39:0] exp_w [N];

    // monitor state, cleared by the monitor when chip enable falls
    logic bits [B + 8];
    int   nb = 0;
    int   hmin = 0, hmax = 0, lmin = 0, lmax = 0;
    int   run = 0;
    bit   in_run = 0;
    int   sdi_bad = 0;
    int   upd_lo = 0;
    int   overlap = 0;
    int   ndone = 0;
    logic ps_sclk = 1'b1, ps_sdi = 1'b0, ps_ce = 1'b1;

    always #2.5 clk = ~clk;

    xp_chain_programmer #(.N_DEV(N), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dev(cfg_dev),
        .cfg_word(cfg_word), .half_len(half_len), .pulse_len(pulse_len),
        .start(start), .xp_ce_n(xp_ce_n), .xp_sclk(xp_sclk), .xp_sdi(xp_sdi),
        .xp_upd_n(xp_upd_n), .xp_serpar(xp_serpar), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic rec(input logic lvl, input int len);
        if (lvl) begin
            if (hmin == 0 || len < hmin) hmin = len;
            if (len > hmax) hmax = len;
        end else begin
            if (lmin == 0 || len < lmin) lmin = len;
            if (len > lmax) lmax = len;
        end
    endtask

    // pin monitor, samples between clock edges
    always @(negedge clk) begin
        if (ps_ce && !xp_ce_n) begin
            nb = 0; hmin = 0; hmax = 0; lmin = 0; lmax = 0;
            sdi_bad = 0; upd_lo = 0; overlap = 0; in_run = 0;
        end
        if (!xp_ce_n && ps_sclk && !xp_sclk) begin
            if (nb < B + 8) bits[nb] = xp_sdi;
            nb++;
        end
        if (!xp_ce_n && xp_upd_n) begin
            if (in_run && xp_sclk == ps_sclk) run++;
            else begin
                if (in_run) rec(ps_sclk, run);
                run = 1;
                in_run = 1;
            end
        end else begin
            if (in_run) rec(ps_sclk, run);
            in_run = 0;
        end
        if (!xp_ce_n && !xp_sclk && !ps_sclk && xp_sdi != ps_sdi) sdi_bad++;
        if (!xp_upd_n) upd_lo++;
        if (!xp_upd_n && (xp_ce_n || nb != B)) overlap++;
        if (done) ndone++;
        ps_sclk = xp_sclk;
        ps_sdi  = xp_sdi;
        ps_ce   = xp_ce_n;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic load_cfg(input int d, input logic [39:0] w, input bit taken);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dev = DW'(d); cfg_word = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (taken) exp_w[d] = w;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // wait for done; checks R9 shape at the pulse
    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 60000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, {tag, " R9 done seen"}, done, 1);
        chk(xp_ce_n && xp_upd_n, {tag, " R9 lines released with done"}, {xp_ce_n, xp_upd_n}, 3);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
    endtask

    task automatic check_stream(input string tag);
        int mism = 0;
        int first = -1;
        int first40 = 0;
        chk(nb == B, {tag, " R2 bit count"}, nb, B);
        for (int d = N - 1; d >= 0; d--) begin
            for (int b = 39; b >= 0; b--) begin
                int p = (N - 1 - d) * 40 + (39 - b);
                logic e = ((b % 5) == 3) ? 1'b1 : exp_w[d][b];
                if (p < nb && bits[p] !== e) begin
                    mism++;
                    if (first < 0) first = p;
                    if (d == N - 1) first40++;
                end
            end
        end
        chk(first40 == 0, {tag, " R3 farthest device word first"}, first40, 0);
        chk(mism == 0, {tag, " R4 R5 stream content (first bad index)"}, first, -1);
    endtask

    task automatic check_timing(input string tag, input int h, input int l);
        chk(hmin == h && hmax == h, {tag, " R6 high phase"}, hmax, h);
        chk(lmin == h && lmax == h, {tag, " R6 low phase"}, lmax, h);
        chk(sdi_bad == 0, {tag, " R6 data moved while clock low"}, sdi_bad, 0);
        chk(upd_lo == l, {tag, " R7 commit pulse length"}, upd_lo, l);
        chk(overlap == 0, {tag, " R8 early commit"}, overlap, 0);
    endtask

    task automatic run_seq(input int h, input int l, input string tag);
        int d0;
        @(negedge clk);
        half_len = CW'(h); pulse_len = CW'(l);
        d0 = ndone;
        pulse_start();
        chk(xp_ce_n == 1'b0 && xp_upd_n == 1'b1, {tag, " R7 enable low, update high"},
            {xp_ce_n, xp_upd_n}, 1);
        wait_done(tag);
        chk(ndone - d0 == 1, {tag, " R9 done count"}, ndone - d0, 1);
    endtask

    task automatic t_reset();
        chk(xp_ce_n === 1'b1 && xp_upd_n === 1'b1, "R1 reset enable/update", {xp_ce_n, xp_upd_n}, 3);
        chk(xp_sclk === 1'b1, "R1 reset clock high", xp_sclk, 1);
        chk(done === 1'b0, "R1 reset done low", done, 0);
        chk(xp_serpar === 1'b0, "R11 serial mode", xp_serpar, 0);
        repeat (5) @(negedge clk);
        chk(xp_upd_n && xp_ce_n && xp_sclk, "R1 idle holds", {xp_ce_n, xp_upd_n, xp_sclk}, 7);
    endtask

    task automatic t_basic();
        load_cfg(0, 40'hA5_5A_C3_3C_F0, 1);
        load_cfg(1, 40'h12_34_56_78_9A, 1);
        load_cfg(2, 40'hF0_0F_E1_1E_D2, 1);
        run_seq(1, 3, "basic");
        check_stream("basic");
        check_timing("basic", 1, 3);
        chk(xp_serpar == 1'b0, "basic R11 serial mode", xp_serpar, 0);
    endtask

    task automatic t_slow();
        load_cfg(0, 40'hFF_FF_FF_FF_FF, 1);
        load_cfg(1, 40'h00_00_00_00_00, 1);
        load_cfg(2, 40'h84_21_08_42_10, 1);
        run_seq(3, 1, "slow");
        check_stream("slow R5 zero word");
        check_timing("slow", 3, 1);
    endtask

    task automatic t_zero();
        load_cfg(1, 40'h3C_C3_5A_A5_0F, 1);
        run_seq(0, 0, "zero");
        check_stream("zero");
        check_timing("zero", 1, 1);
    endtask

    task automatic t_busy();
        int d0;
        @(negedge clk);
        half_len = 8'd2; pulse_len = 8'd2;
        d0 = ndone;
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        load_cfg(0, 40'h55_55_55_55_55, 0);
        load_cfg(2, 40'h00_00_00_00_01, 0);
        wait_done("busy");
        check_stream("busy R10 loads ignored in flight");
        repeat (30) @(negedge clk);
        chk(ndone - d0 == 1, "busy R10 start ignored", ndone - d0, 1);
        chk(xp_ce_n == 1'b1, "busy R10 no second run", xp_ce_n, 1);
        run_seq(1, 1, "after");
        check_stream("after R10 stored words unchanged");
    endtask

    initial begin
        for (int d = 0; d < N; d++) exp_w[d] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_slow();
        t_zero();
        t_busy();
        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule